// File: doc/BRIEF.md
# Software-Filled Data Translation Cache

This block is a small, fully associative cache of address translations that only software fills. Each entry maps a 20-bit virtual page number (4 KB pages, 32-bit virtual addresses) to a physical page number. Each entry also carries a valid bit, an access bit and a dirty bit. No hardware page walk exists. Translations arrive only through the insert pins, and they are removed through the single-page invalidate pins or the flush pin.

Lookups flow through a valid/ready request stream and return on a valid/ready response stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response port after that edge and stays there unchanged until `rsp_ready` takes it. `req_ready` is low while a response is waiting and not being taken. It is also low in any cycle where software drives a control operation.

A hit on an entry whose access bit is clear raises an access-bit fault. A store that hits an entry whose dirty bit is clear raises a dirty-bit fault. The cache never sets either bit itself. Entries are replaced in least-recently-used order, where both an insertion and a lookup hit count as a use. The most recent `ENTRIES` entries used are therefore always kept, which lets an instruction that touches many pages make forward progress.

Top module: `xlat_cache`

## Requirements
- R1: An accepted lookup that hits returns `rsp_miss`=0 and `rsp_paddr` = {stored PPN, `req_vaddr[11:0]`}. The response is valid from the clock edge after acceptance.
- R2: An accepted lookup that misses returns `rsp_miss`=1, `rsp_paddr`=0 and both fault flags at 0. It changes no entry and no recency order.
- R3: A hit on an entry whose access bit is 0 returns `rsp_acc_fault`=1. The bit is never set by hardware, so a repeated lookup faults again.
- R4: A store (`req_store`=1) that hits an entry whose dirty bit is 0 returns `rsp_dirty_fault`=1. A load never raises it, and hardware never sets the bit.
- R5: An insert whose VPN matches a valid entry overwrites that entry in place. Otherwise it fills the lowest-numbered invalid entry. If none is invalid, it replaces the least recently inserted-or-hit entry.
- R6: The `ENTRIES` entries most recently inserted or hit are never evicted by an insert.
- R7: `inv_en` clears only the valid entry whose VPN equals `inv_vpn`, and every other entry stays usable.
- R8: `flush_all` clears every valid bit in a single cycle.
- R9: `req_ready` is 0 in any cycle where `flush_all`, `inv_en` or `ins_en` is high. When several are high together, only the highest-priority one takes effect, in the order flush over invalidate over insert.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold steady and `req_ready` is 0.
- R11: After reset, `rsp_valid` is 0 and every entry is invalid.
- R12: At most one entry matches any virtual page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store reference, 0 = load |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_miss | output | 1 | No entry matched |
| rsp_paddr | output | 36 | Physical address (0 on miss) |
| rsp_acc_fault | output | 1 | Hit on an entry with access bit clear |
| rsp_dirty_fault | output | 1 | Store hit on an entry with dirty bit clear |
| ins_en | input | 1 | Insert a translation this cycle |
| ins_vpn | input | 20 | Virtual page number to insert |
| ins_ppn | input | 24 | Physical page number to insert |
| ins_acc | input | 1 | Access bit for the inserted entry |
| ins_dirty | input | 1 | Dirty bit for the inserted entry |
| inv_en | input | 1 | Invalidate one page this cycle |
| inv_vpn | input | 20 | Virtual page to invalidate |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The assertions check the stream rules on every cycle. They confirm that a held response stays stable and that an accepted request always yields a response. They also confirm that control operations stall requests, that a miss never carries a fault or an address, that a flush empties the valid vector, and that no page ever matches two entries. The directed scenarios are the only way to show which entry an insert replaces, that the most recent entries survive, and that overwrite in place and free-slot preference work. They also show that misses leave the recency order alone and that the fault bits stay clear across repeated references.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    PICK_SAME   = 2'd0,
    PICK_FREE   = 2'd1,
    PICK_OLDEST = 2'd2
  } pick_e;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int N  = 8,
  parameter int W  = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        vld,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  output logic                hit,
  output logic [N-1:0]        onehot,
  output logic [IW-1:0]       idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign onehot[g] = vld[g] && (tags[g] == key);
  end

  assign hit = |onehot;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/xc_free.sv
module xc_free #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xc_age.sv
module xc_age #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  // Each entry holds a distinct rank; 0 is the most recent use.
  logic [N-1:0][IW-1:0] rank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)          rank[i] <= '0;
        else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (rank[i] == IW'(N - 1)) oldest_idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int PPN_W   = 24,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PA_W   = PPN_W + PAGE_W,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_miss,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_acc_fault,
  output logic             rsp_dirty_fault,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic             ins_acc,
  input  logic             ins_dirty,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush_all
);
  import xc_pkg::*;

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0]             ent_acc;
  logic [ENTRIES-1:0]             ent_dty;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;

  // Lookup port match
  logic               lk_hit;
  logic [ENTRIES-1:0] lk_oh;
  logic [IW-1:0]      lk_idx;
  xc_match #(.N(ENTRIES), .W(VPN_W)) u_lk (
    .vld(ent_vld), .tags(ent_vpn), .key(req_vaddr[VA_W-1:PAGE_W]),
    .hit(lk_hit), .onehot(lk_oh), .idx(lk_idx)
  );

  // Insert port match (overwrite in place)
  logic               is_hit;
  logic [ENTRIES-1:0] is_oh;
  logic [IW-1:0]      is_idx;
  xc_match #(.N(ENTRIES), .W(VPN_W)) u_is (
    .vld(ent_vld), .tags(ent_vpn), .key(ins_vpn),
    .hit(is_hit), .onehot(is_oh), .idx(is_idx)
  );

  // Invalidate port match
  logic               iv_hit;
  logic [ENTRIES-1:0] iv_oh;
  logic [IW-1:0]      iv_idx;
  xc_match #(.N(ENTRIES), .W(VPN_W)) u_iv (
    .vld(ent_vld), .tags(ent_vpn), .key(inv_vpn),
    .hit(iv_hit), .onehot(iv_oh), .idx(iv_idx)
  );

  logic          any_free;
  logic [IW-1:0] free_idx;
  xc_free #(.N(ENTRIES)) u_free (
    .vld(ent_vld), .any_free(any_free), .free_idx(free_idx)
  );

  logic          touch;
  logic [IW-1:0] touch_idx;
  logic [IW-1:0] oldest_idx;
  xc_age #(.N(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .touch(touch),
    .touch_idx(touch_idx), .oldest_idx(oldest_idx)
  );

  // Control priority: flush, then invalidate, then insert.
  logic ctl_busy, do_inv, do_ins, accept;
  assign ctl_busy = flush_all | inv_en | ins_en;
  assign do_inv   = !flush_all && inv_en;
  assign do_ins   = !flush_all && !inv_en && ins_en;
  assign req_ready = !ctl_busy && (!rsp_valid || rsp_ready);
  assign accept   = req_valid && req_ready;

  pick_e         pick;
  logic [IW-1:0] tgt;
  always_comb begin
    if (is_hit)        pick = PICK_SAME;
    else if (any_free) pick = PICK_FREE;
    else               pick = PICK_OLDEST;
    unique case (pick)
      PICK_SAME: tgt = is_idx;
      PICK_FREE: tgt = free_idx;
      default:   tgt = oldest_idx;
    endcase
  end

  assign touch     = do_ins || (accept && lk_hit);
  assign touch_idx = do_ins ? tgt : lk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_acc <= '0;
      ent_dty <= '0;
      ent_vpn <= '0;
      ent_ppn <= '0;
    end else if (flush_all) begin
      ent_vld <= '0;
    end else if (do_inv) begin
      if (iv_hit) ent_vld[iv_idx] <= 1'b0;
    end else if (do_ins) begin
      ent_vld[tgt] <= 1'b1;
      ent_acc[tgt] <= ins_acc;
      ent_dty[tgt] <= ins_dirty;
      ent_vpn[tgt] <= ins_vpn;
      ent_ppn[tgt] <= ins_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_miss        <= 1'b0;
      rsp_paddr       <= '0;
      rsp_acc_fault   <= 1'b0;
      rsp_dirty_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid       <= 1'b1;
      rsp_miss        <= !lk_hit;
      rsp_paddr       <= lk_hit ? {ent_ppn[lk_idx], req_vaddr[PAGE_W-1:0]} : '0;
      rsp_acc_fault   <= lk_hit && !ent_acc[lk_idx];
      rsp_dirty_fault <= lk_hit && req_store && !ent_dty[lk_idx];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
  parameter int N    = 8,
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_miss,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_acc_fault,
  input logic            rsp_dirty_fault,
  input logic            ins_en,
  input logic            inv_en,
  input logic            flush_all,
  input logic [N-1:0]    ent_vld,
  input logic [N-1:0]    lk_oh
);
  assert_accept_gives_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_miss_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (!rsp_acc_fault && !rsp_dirty_fault && rsp_paddr == '0));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_vld == '0));

  assert_ctl_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en || inv_en || flush_all) |-> !req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss)
      && $stable(rsp_acc_fault) && $stable(rsp_dirty_fault)));

  assert_hold_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_unique_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_oh));
endmodule

bind xlat_cache xc_chk #(.N(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_miss(rsp_miss),
  .rsp_paddr(rsp_paddr), .rsp_acc_fault(rsp_acc_fault),
  .rsp_dirty_fault(rsp_dirty_fault), .ins_en(ins_en), .inv_en(inv_en),
  .flush_all(flush_all), .ent_vld(ent_vld), .lk_oh(lk_oh)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_miss;
  logic [35:0] rsp_paddr;
  logic        rsp_acc_fault, rsp_dirty_fault;
  logic        ins_en = 1'b0;
  logic [19:0] ins_vpn = '0;
  logic [23:0] ins_ppn = '0;
  logic        ins_acc = 1'b0, ins_dirty = 1'b0;
  logic        inv_en = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        flush_all = 1'b0;

  int total = 0;
  int bad = 0;

  logic        got_miss, got_af, got_df;
  logic [35:0] got_pa;

  always #2 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .rsp_acc_fault(rsp_acc_fault), .rsp_dirty_fault(rsp_dirty_fault),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_acc(ins_acc),
    .ins_dirty(ins_dirty), .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_all(flush_all)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [19:0] v, input logic [23:0] p, input logic a,
                     input logic d);
    @(negedge clk);
    ins_en = 1'b1; ins_vpn = v; ins_ppn = p; ins_acc = a; ins_dirty = d;
    @(negedge clk);
    ins_en = 1'b0;
  endtask

  task automatic kill(input logic [19:0] v);
    @(negedge clk);
    inv_en = 1'b1; inv_vpn = v;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic st);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_miss = rsp_miss; got_pa = rsp_paddr;
    got_af = rsp_acc_fault; got_df = rsp_dirty_fault;
    chk(rsp_valid, "R1 rsp_valid", 64'(rsp_valid), 64'd1);
  endtask

  task automatic expect_hit(input logic [19:0] v, input logic [23:0] p,
                            input logic [11:0] off, input string req);
    look({v, off}, 1'b0);
    chk(!got_miss && got_pa == {p, off}, req, {27'd0, got_miss, got_pa},
        {28'd0, p, off});
  endtask

  task automatic expect_miss(input logic [19:0] v, input string req);
    look({v, 12'h010}, 1'b0);
    chk(got_miss && got_pa == '0 && !got_af && !got_df, req,
        {27'd0, got_miss, got_pa}, {27'd0, 1'b1, 36'd0});
  endtask

  task automatic t_reset;
    chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R11 req_ready after reset", 64'(req_ready), 64'd1);
    expect_miss(20'h12345, "R11 empty after reset");
    expect_miss(20'h00000, "R2 miss on page zero");
  endtask

  task automatic t_fill_replace;
    for (int i = 0; i < 8; i++) put(20'h100 + 20'(i), 24'hA00 + 24'(i), 1'b1, 1'b1);
    for (int i = 0; i < 8; i++)
      expect_hit(20'h100 + 20'(i), 24'hA00 + 24'(i), 12'h5A4, "R1 fill hit");
    expect_hit(20'h100, 24'hA00, 12'hFFF, "R1 touch oldest");
    expect_miss(20'h999, "R2 miss keeps order");
    put(20'h200, 24'hC00, 1'b1, 1'b1);
    expect_miss(20'h101, "R5 least recent evicted");
    expect_hit(20'h100, 24'hA00, 12'h000, "R6 recently hit kept");
    for (int i = 2; i < 8; i++)
      expect_hit(20'h100 + 20'(i), 24'hA00 + 24'(i), 12'h123, "R6 recent kept");
    expect_hit(20'h200, 24'hC00, 12'h321, "R6 newest kept");
  endtask

  task automatic t_overwrite;
    put(20'h200, 24'hBEEF, 1'b1, 1'b1);
    expect_hit(20'h200, 24'hBEEF, 12'h777, "R5 overwrite in place");
    expect_hit(20'h100, 24'hA00, 12'h001, "R12 overwrite evicts none");
    expect_hit(20'h102, 24'hA02, 12'h002, "R12 overwrite evicts none");
  endtask

  task automatic t_faults;
    put(20'h300, 24'h300, 1'b0, 1'b1);
    look({20'h300, 12'h0}, 1'b0);
    chk(!got_miss && got_af && !got_df, "R3 access fault", {got_miss, got_af, got_df}, 64'b010);
    look({20'h300, 12'h4}, 1'b1);
    chk(got_af && !got_df, "R3 access bit not set", {got_af, got_df}, 64'b10);
    put(20'h301, 24'h301, 1'b1, 1'b0);
    look({20'h301, 12'h8}, 1'b1);
    chk(!got_af && got_df, "R4 dirty fault on store", {got_af, got_df}, 64'b01);
    look({20'h301, 12'h8}, 1'b0);
    chk(!got_af && !got_df && got_pa == {24'h301, 12'h8}, "R4 load no dirty fault",
        {got_af, got_df}, 64'b00);
    look({20'h301, 12'hC}, 1'b1);
    chk(got_df, "R4 dirty bit not set", 64'(got_df), 64'd1);
  endtask

  task automatic t_flush_inval;
    @(negedge clk);
    flush_all = 1'b1;
    #0.1;
    chk(req_ready == 1'b0, "R9 stall during flush", 64'(req_ready), 64'd0);
    @(negedge clk);
    flush_all = 1'b0;
    expect_miss(20'h300, "R8 flushed");
    expect_miss(20'h301, "R8 flushed");
    expect_miss(20'h200, "R8 flushed");
    for (int i = 0; i < 8; i++) put(20'h400 + 20'(i), 24'hD00 + 24'(i), 1'b1, 1'b1);
    kill(20'h403);
    expect_miss(20'h403, "R7 page invalidated");
    expect_hit(20'h402, 24'hD02, 12'h0AB, "R7 neighbour kept");
    put(20'h500, 24'hE00, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++)
      if (i != 3) expect_hit(20'h400 + 20'(i), 24'hD00 + 24'(i), 12'h0CD, "R5 free slot used");
    expect_hit(20'h500, 24'hE00, 12'h0EF, "R5 free slot used");
  endtask

  task automatic t_priority;
    @(negedge clk);
    inv_en = 1'b1; inv_vpn = 20'h400;
    ins_en = 1'b1; ins_vpn = 20'h600; ins_ppn = 24'h600; ins_acc = 1'b1; ins_dirty = 1'b1;
    #0.1;
    chk(req_ready == 1'b0, "R9 stall during control", 64'(req_ready), 64'd0);
    @(negedge clk);
    inv_en = 1'b0; ins_en = 1'b0;
    expect_miss(20'h400, "R9 invalidate wins");
    expect_miss(20'h600, "R9 insert dropped");
  endtask

  task automatic t_backpressure;
    logic [35:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = {20'h402, 12'h111}; req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {20'h404, 12'h222};
    held = rsp_paddr;
    chk(rsp_valid && held == {24'hD02, 12'h111}, "R10 response shown", {28'd0, held},
        {28'd0, 24'hD02, 12'h111});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == held && !req_ready, "R10 response held",
          {27'd0, req_ready, rsp_paddr}, {28'd0, held});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_paddr == {24'hD04, 12'h222}, "R10 next after release",
        {28'd0, rsp_paddr}, {28'd0, 24'hD04, 12'h222});
    @(negedge clk);
    chk(!rsp_valid, "R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_replace();
    t_overwrite();
    t_faults();
    t_flush_inval();
    t_priority();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule